// File: doc/BRIEF.md
# Segment Access Guard

This block screens one protected-mode memory access against the state of the segment it uses. Each request carries the virtual address and an access size. It also carries write and execute qualifiers, the segment index, and that segment's selector, base, limit and attribute bits (readable, writable, expand-down). Two more inputs set the effective address width: the code segment's default-size bit and an address-size override. The block answers with a general-protection fault flag, whose error code is always zero. It also returns the segment offset and, when the access is legal, the linear address for a later paging stage.

Requests enter over a valid/ready stream and results leave over another. An input beat is taken when `in_valid` and `in_ready` are both high on a rising clock edge. A result stays on the output until `out_valid` and `out_ready` are both high on an edge. By default one output register sits between the two streams. A new request is accepted only when that register is empty or is being drained in the same cycle. While the consumer holds `out_ready` low, the stored result does not change and `in_ready` stays low. Setting `REGISTER_OUT` to 0 turns the block into a pure combinational pass-through: valid and ready are forwarded unchanged.

Top module: `seg_access_guard`

## Requirements
- R1: A request whose selector is zero raises the fault. `out_errcode` is always zero.
- R2: Attribute checks apply only to data-class segment indices 0 to 6. For those, a write to a non-writable segment faults. An access with neither write nor execute set faults on a non-readable segment. For indices 7 to 15 the attribute bits have no effect.
- R3: The expand-down attribute takes effect only for segment indices 0 to 6. Every other index is checked as expand-up.
- R4: The effective address width is 16 bits when `in_cs_big` equals `in_asz_ovr`, and 32 bits otherwise.
- R5: `out_offset` equals (vaddr − base) truncated to the effective width and zero-extended to 32 bits.
- R6: The size code maps 0, 1, 2 and 3 to 1, 2, 4 and 8 bytes. The end offset is offset + bytes − 1, computed at 33 bits with no truncation, so a carry past the top of the range is seen by the compare.
- R7: For an expand-up segment, the access faults when either the offset or the end offset is greater than the limit.
- R8: For an expand-down segment, the access faults when either the offset or the end offset is less than or equal to the limit.
- R9: With no fault, `out_lin` is base + offset modulo 2^32. With a fault, `out_lin` is zero.
- R10: After reset `out_valid` is low and `in_ready` is high. `in_ready` equals (not `out_valid`) or `out_ready`. A result held under back-pressure stays unchanged until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted this cycle when high with in_valid |
| in_vaddr | input | 32 | Virtual address |
| in_size | input | 2 | Size code (1, 2, 4, 8 bytes) |
| in_write | input | 1 | Access is a write |
| in_exec | input | 1 | Access is an instruction fetch |
| in_seg | input | 4 | Segment index |
| in_sel | input | 16 | Segment selector |
| in_base | input | 32 | Segment base |
| in_limit | input | 32 | Segment limit |
| in_attr_rd | input | 1 | Segment readable |
| in_attr_wr | input | 1 | Segment writable |
| in_attr_xd | input | 1 | Segment expands down |
| in_cs_big | input | 1 | Code segment default size is 32-bit |
| in_asz_ovr | input | 1 | Address-size override present |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes result |
| out_fault | output | 1 | General-protection fault |
| out_errcode | output | 16 | Fault error code (always zero) |
| out_offset | output | 32 | Segment offset |
| out_lin | output | 32 | Linear address, zero on fault |

## Verification
The hardest case to reach from the ports is the narrow-width wrap. A 16-bit offset must land at or just below 0xFFFF so that the end offset carries into bit 16, and the limit must sit exactly at the boundary. Random bases and addresses almost never produce this. The stimulus therefore builds the virtual address as base plus a chosen offset, places the limit within a few bytes of the offset, and adds directed vectors for the carry-out and exact-limit cases. These cover both widths and both expansion directions.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;
  localparam int unsigned SEL_W  = 16;
  localparam int unsigned CODE_W = 16;

  typedef struct packed {
    logic readable;
    logic writable;
    logic expand_down;
  } seg_attr_t;

  function automatic logic [3:0] size_to_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction
endpackage

// File: rtl/seg_offset_calc.sv
module seg_offset_calc
  import seg_chk_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned NARROW_W = 16
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [ADDR_W-1:0] base,
  input  logic [1:0]        size_code,
  input  logic              cs_big,
  input  logic              asz_ovr,
  output logic [ADDR_W-1:0] offset,
  output logic [ADDR_W:0]   end_off
);
  localparam logic [ADDR_W-1:0] NARROW_MASK = {{(ADDR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic              narrow;
  logic [ADDR_W-1:0] diff;

  always_comb begin
    narrow  = (cs_big == asz_ovr);
    diff    = vaddr - base;
    offset  = narrow ? (diff & NARROW_MASK) : diff;
    end_off = {1'b0, offset} + (ADDR_W+1)'(size_to_bytes(size_code)) - (ADDR_W+1)'(1);
  end

  always_comb begin
    if (narrow) assert_narrow_offset_R4: assert (offset[ADDR_W-1:NARROW_W] == '0);
  end
endmodule

// File: rtl/seg_perm_check.sv
module seg_perm_check
  import seg_chk_pkg::*;
#(
  parameter int unsigned SEG_W   = 4,
  parameter int unsigned DATA_LO = 0,
  parameter int unsigned DATA_HI = 6
) (
  input  logic [SEG_W-1:0] seg_idx,
  input  logic [SEL_W-1:0] selector,
  input  seg_attr_t        attr,
  input  logic             is_write,
  input  logic             is_exec,
  output logic             null_fault,
  output logic             perm_fault,
  output logic             expand_down
);
  localparam int unsigned NSEG = 1 << SEG_W;

  function automatic logic [NSEG-1:0] build_mask();
    logic [NSEG-1:0] m;
    for (int i = 0; i < NSEG; i++) m[i] = (i >= int'(DATA_LO)) && (i <= int'(DATA_HI));
    return m;
  endfunction

  localparam logic [NSEG-1:0] DATA_MASK = build_mask();

  logic data_class;

  always_comb begin
    data_class  = DATA_MASK[seg_idx];
    null_fault  = (selector == '0);
    perm_fault  = 1'b0;
    if (data_class) begin
      if (is_write && !attr.writable) perm_fault = 1'b1;
      if (!is_write && !is_exec && !attr.readable) perm_fault = 1'b1;
    end
    expand_down = data_class && attr.expand_down;
  end

  always_comb begin
    if (!DATA_MASK[seg_idx]) assert_nondata_no_perm_R2: assert (!perm_fault);
  end
endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] offset,
  input  logic [ADDR_W:0]   end_off,
  input  logic [ADDR_W-1:0] limit,
  input  logic              expand_down,
  output logic              limit_fault
);
  logic [ADDR_W:0] lim_w;
  logic            lo_out, hi_out;

  always_comb begin
    lim_w  = {1'b0, limit};
    hi_out = ({1'b0, offset} > lim_w) || (end_off > lim_w);
    lo_out = ({1'b0, offset} <= lim_w) || (end_off <= lim_w);
    limit_fault = expand_down ? lo_out : hi_out;
  end

  always_comb begin
    if (!expand_down && !limit_fault) assert_up_inside_R7: assert (end_off <= {1'b0, limit});
    if (expand_down && !limit_fault) assert_down_inside_R8: assert ({1'b0, offset} > {1'b0, limit});
  end
endmodule

// File: rtl/seg_access_guard.sv
module seg_access_guard
  import seg_chk_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned SEG_W        = 4,
  parameter int unsigned DATA_LO      = 0,
  parameter int unsigned DATA_HI      = 6,
  parameter bit          REGISTER_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_vaddr,
  input  logic [1:0]        in_size,
  input  logic              in_write,
  input  logic              in_exec,
  input  logic [SEG_W-1:0]  in_seg,
  input  logic [15:0]       in_sel,
  input  logic [ADDR_W-1:0] in_base,
  input  logic [ADDR_W-1:0] in_limit,
  input  logic              in_attr_rd,
  input  logic              in_attr_wr,
  input  logic              in_attr_xd,
  input  logic              in_cs_big,
  input  logic              in_asz_ovr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_fault,
  output logic [15:0]       out_errcode,
  output logic [ADDR_W-1:0] out_offset,
  output logic [ADDR_W-1:0] out_lin
);
  seg_attr_t         attr;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W:0]   end_off;
  logic              null_f, perm_f, lim_f, xd_eff;
  logic              c_fault;
  logic [ADDR_W-1:0] c_lin;

  assign attr = '{readable: in_attr_rd, writable: in_attr_wr, expand_down: in_attr_xd};

  seg_offset_calc #(.ADDR_W(ADDR_W)) u_off (
    .vaddr(in_vaddr), .base(in_base), .size_code(in_size),
    .cs_big(in_cs_big), .asz_ovr(in_asz_ovr),
    .offset(offset), .end_off(end_off)
  );

  seg_perm_check #(.SEG_W(SEG_W), .DATA_LO(DATA_LO), .DATA_HI(DATA_HI)) u_perm (
    .seg_idx(in_seg), .selector(in_sel), .attr(attr),
    .is_write(in_write), .is_exec(in_exec),
    .null_fault(null_f), .perm_fault(perm_f), .expand_down(xd_eff)
  );

  seg_limit_check #(.ADDR_W(ADDR_W)) u_lim (
    .offset(offset), .end_off(end_off), .limit(in_limit),
    .expand_down(xd_eff), .limit_fault(lim_f)
  );

  // Priority: null selector, then permission, then limit; one merged flag.
  always_comb begin
    c_fault = null_f || perm_f || lim_f;
    c_lin   = c_fault ? '0 : (in_base + offset);
  end

  assign out_errcode = '0;

  always_comb begin
    if (null_f) assert_null_faults_R1: assert (c_fault);
  end

  generate
    if (REGISTER_OUT) begin : g_reg
      logic              v_q, f_q;
      logic [ADDR_W-1:0] off_q, lin_q;

      assign in_ready = !v_q || out_ready;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q   <= 1'b0;
          f_q   <= 1'b0;
          off_q <= '0;
          lin_q <= '0;
        end else if (in_ready) begin
          v_q <= in_valid;
          if (in_valid) begin
            f_q   <= c_fault;
            off_q <= offset;
            lin_q <= c_lin;
          end
        end
      end

      assign out_valid  = v_q;
      assign out_fault  = f_q;
      assign out_offset = off_q;
      assign out_lin    = lin_q;

      assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_fault) &&
        $stable(out_offset) && $stable(out_lin));
      assert_lin_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_fault |-> out_lin == '0);
      assert_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);
    end else begin : g_comb
      assign in_ready   = out_ready;
      assign out_valid  = in_valid;
      assign out_fault  = c_fault;
      assign out_offset = offset;
      assign out_lin    = c_lin;
    end
  endgenerate
endmodule

// File: tb/seg_access_guard_tb.sv
`timescale 1ns/100ps
module seg_access_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [31:0] in_vaddr = '0, in_base = '0, in_limit = '0;
  logic [1:0]  in_size = '0;
  logic        in_write = 0, in_exec = 0;
  logic [3:0]  in_seg = '0;
  logic [15:0] in_sel = '0;
  logic        in_attr_rd = 0, in_attr_wr = 0, in_attr_xd = 0;
  logic        in_cs_big = 0, in_asz_ovr = 0;
  logic        out_valid, out_ready = 1'b0, out_fault;
  logic [15:0] out_errcode;
  logic [31:0] out_offset, out_lin;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  seg_access_guard u_dut (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic string pick_tag(input logic xd_eff, input logic narrow);
    if (in_sel == 0) return "R1";
    if (in_seg > 6) return "R2";
    if (xd_eff) return narrow ? "R8,R4" : "R8";
    return narrow ? "R7,R4" : "R7";
  endfunction

  task automatic apply(input int stall);
    logic        narrow, data, xd, f;
    logic [31:0] diff, off, lin;
    logic [32:0] endo, lim;
    string       tag;
    narrow = (in_cs_big == in_asz_ovr);
    diff   = in_vaddr - in_base;
    off    = narrow ? {16'h0, diff[15:0]} : diff;
    endo   = {1'b0, off} + 33'(1 << in_size) - 33'd1;
    lim    = {1'b0, in_limit};
    data   = (in_seg <= 4'd6);
    xd     = data && in_attr_xd;
    if (in_sel == 0) f = 1;
    else if (data && in_write && !in_attr_wr) f = 1;
    else if (data && !in_write && !in_exec && !in_attr_rd) f = 1;
    else if (xd) f = ({1'b0, off} <= lim) || (endo <= lim);
    else f = ({1'b0, off} > lim) || (endo > lim);
    lin = f ? 32'h0 : in_base + off;
    tag = pick_tag(xd, narrow);
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      check("R10 in_ready low under stall", 64'(in_ready), 64'd0);
    end
    check({tag, " fault"}, 64'(out_fault), 64'(f));
    check("R5 offset", 64'(out_offset), 64'(off));
    check("R9 linear", 64'(out_lin), 64'(lin));
    check("R1 errcode", 64'(out_errcode), 64'd0);
    check("R10 out_valid", 64'(out_valid), 64'd1);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic setup(input logic [31:0] base, input logic [31:0] off, input logic [31:0] lim,
                       input logic [1:0] sz, input logic big, input logic ovr, input logic xd,
                       input logic [3:0] seg);
    in_base = base; in_vaddr = base + off; in_limit = lim; in_size = sz;
    in_cs_big = big; in_asz_ovr = ovr; in_attr_xd = xd; in_seg = seg;
    in_sel = 16'h0010; in_attr_rd = 1; in_attr_wr = 1; in_write = 0; in_exec = 0;
  endtask

  initial begin : watchdog
    #900000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R10 reset out_valid", 64'(out_valid), 64'd0);
    check("R10 reset in_ready", 64'(in_ready), 64'd1);

    // R7 exact limit, 32-bit width
    setup(32'h1000, 32'h20, 32'h20, 2'd0, 1, 0, 0, 4'd3); apply(0);
    setup(32'h1000, 32'h20, 32'h20, 2'd1, 1, 0, 0, 4'd3); apply(2);
    // R8 expand-down boundary
    setup(32'h1000, 32'h21, 32'h20, 2'd3, 0, 1, 1, 4'd2); apply(0);
    setup(32'h1000, 32'h20, 32'h20, 2'd0, 0, 1, 1, 4'd2); apply(1);
    // R4 R6 narrow wrap: offset 0xFFFF, size 2 carries past 16 bits
    setup(32'h1000, 32'hFFFF_FFFF, 32'hFFFF, 2'd1, 0, 0, 0, 4'd3); apply(0);
    setup(32'h1000, 32'hFFFF_FFFF, 32'hFFFF, 2'd0, 1, 1, 0, 4'd3); apply(0);
    // R4 same offset at 32 bits is large
    setup(32'h1000, 32'h0001_0004, 32'hFFFF_FFFF, 2'd2, 1, 0, 0, 4'd4); apply(0);
    // R3 expand-down ignored for non-data index
    setup(32'h0, 32'h10, 32'h20, 2'd0, 1, 0, 1, 4'd9); apply(0);
    // R1 null selector
    setup(32'h0, 32'h10, 32'hFFFF, 2'd0, 1, 0, 0, 4'd3); in_sel = 0; apply(0);
    // R2 write to non-writable, read of non-readable, exec ok
    setup(32'h0, 32'h10, 32'hFFFF, 2'd0, 1, 0, 0, 4'd3); in_attr_wr = 0; in_write = 1; apply(0);
    setup(32'h0, 32'h10, 32'hFFFF, 2'd0, 1, 0, 0, 4'd3); in_attr_rd = 0; apply(0);
    setup(32'h0, 32'h10, 32'hFFFF, 2'd0, 1, 0, 0, 4'd3); in_attr_rd = 0; in_exec = 1; apply(0);
    setup(32'h0, 32'h10, 32'hFFFF, 2'd0, 1, 0, 0, 4'd11); in_attr_rd = 0; in_attr_wr = 0;
    in_write = 1; apply(0);

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] off, base;
      int dl;
      base = $urandom;
      off  = ($urandom_range(0, 3) == 0) ? 32'hFFFF - $urandom_range(0, 8) : $urandom;
      dl   = int'($urandom_range(0, 18)) - 9;
      setup(base, off, 32'(int'(off[15:0]) + dl), 2'($urandom_range(0, 3)),
            1'($urandom), 1'($urandom), 1'($urandom), 4'($urandom));
      if ($urandom_range(0, 1) == 1) in_limit = off + 32'(dl);
      if ($urandom_range(0, 9) == 0) in_limit = $urandom;
      if ($urandom_range(0, 15) == 0) in_sel = 0;
      in_attr_rd = ($urandom_range(0, 7) != 0);
      in_attr_wr = ($urandom_range(0, 7) != 0);
      in_write   = 1'($urandom);
      in_exec    = ($urandom_range(0, 5) == 0);
      apply(int'($urandom_range(0, 2)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule